// File: doc/BRIEF.md
# Accumulator Status Flag Generator

This block produces the seven condition flags that follow an operation on a 40-bit accumulator. The flags are carry, overflow, sticky overflow, zero, negative, extension and unnormalized. The datapath gives it three operands: the destination value before the operation, the source value, and the result. The instruction decoder gives it one small rule selector per flag. Each selector either picks one of several equations over the sign bits at positions 39, 31 and 15, or asks for the flag to keep its current value.

All flag updates share one clock enable and appear on the outputs in the cycle after the enabling edge. Sticky overflow collects every overflow the block sees. Only reset or the dedicated clear input brings it back to 0. The asynchronous active-low reset is released synchronously inside the block, so the flags stay in their reset state for two more edges after `rst_n` rises.

Top module: `acc_flag_gen`

## Requirements
- R1: While reset is active, and for the two clock edges after `rst_n` rises, every flag output is 0.
- R2: Carry select code 1 clears the carry. Code 2 sets it to d39&s39 | ~r39&(d39|s39), the add form. Code 3 sets it to d39&~s39 | ~r39&(d39|~s39), the subtract form. Here d, s and r are `dst`, `src` and `res`.
- R3: Carry select code 4 compares d39 with s15. If they differ, it uses the add form; if they are equal, it uses the subtract form. In both cases s15 stands in place of s39.
- R4: Carry select code 5 gives ~d39&~r39, and code 6 gives d39&~r39.
- R5: Overflow select codes work as follows:
  - 1 clears the flag.
  - 2 gives d39&s39&~r39 | ~d39&~s39&r39.
  - 3 gives d39&~s39&~r39 | ~d39&s39&r39.
  - 4 gives d39&r39.
  - 5 gives ~d39&r39.
  - 6 gives r39.
  - 7 gives d39&~r39.
- R6: On an enabled edge where the overflow flag's new value is 1, including a value kept by code 0, sticky overflow becomes 1. It falls only on reset or on an edge with `sv_clr` high. The clear wins over a set on the same edge.
- R7: Zero select code 1 sets the flag when all 40 result bits are 0. Code 2 sets it when result bits 31:16 are 0.
- R8: Negative select code 1 copies result bit 39, and code 2 copies result bit 31.
- R9: When `e_upd` is 1, the extension flag becomes 1 exactly when result bits 39:31 are neither all zeros nor all ones.
- R10: When `u_upd` is 1, the unnormalized flag becomes the XNOR of result bits 31 and 30.
- R11: Some inputs leave flags unchanged:
  - With `upd_en` low, no flag changes except through `sv_clr`.
  - Carry code 0 or 7 keeps the carry.
  - Overflow code 0 keeps the overflow flag.
  - Zero or negative code 0 or 3 keeps that flag.
  - `e_upd` or `u_upd` at 0 keeps that flag.
- R12: A flag selected on an enabled edge shows its new value on the outputs right after that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Clock enable for all rule-driven flag updates |
| sv_clr | input | 1 | Clears sticky overflow |
| dst | input | 40 | Destination operand before the operation |
| src | input | 40 | Source operand |
| res | input | 40 | Operation result |
| c_sel | input | 3 | Carry rule select |
| v_sel | input | 3 | Overflow rule select |
| z_sel | input | 2 | Zero rule select |
| n_sel | input | 2 | Negative rule select |
| e_upd | input | 1 | Update extension flag |
| u_upd | input | 1 | Update unnormalized flag |
| flag_c | output | 1 | Carry |
| flag_v | output | 1 | Overflow |
| flag_sv | output | 1 | Sticky overflow |
| flag_z | output | 1 | Zero |
| flag_n | output | 1 | Negative |
| flag_e | output | 1 | Extension |
| flag_u | output | 1 | Unnormalized |

## Verification
The assertions check these properties on every cycle:
- Flags hold while the enable is low.
- Sticky overflow never falls without a clear.
- A set overflow after an enabled edge without a clear leaves sticky overflow set.
- The extension and unnormalized flags follow the result bits of the previous cycle.

The actual equation chosen by each carry, overflow, zero and negative code can only be shown by the bench's reference model. So can the mixed-width carry rule and the boundary patterns of the extension window. The bench drives directed cases and a long run with random selectors, and compares the model with the outputs after every edge.

// File: rtl/acc_flag_pkg.sv
package acc_flag_pkg;

  typedef enum logic [2:0] {
    CS_KEEP  = 3'd0,
    CS_CLR   = 3'd1,
    CS_ADD   = 3'd2,
    CS_SUB   = 3'd3,
    CS_MIXED = 3'd4,
    CS_NDNR  = 3'd5,
    CS_DNR   = 3'd6,
    CS_KEEP2 = 3'd7
  } carry_sel_e;

  typedef enum logic [2:0] {
    VS_KEEP = 3'd0,
    VS_CLR  = 3'd1,
    VS_ADD  = 3'd2,
    VS_SUB  = 3'd3,
    VS_DR   = 3'd4,
    VS_NDR  = 3'd5,
    VS_R    = 3'd6,
    VS_DNR  = 3'd7
  } ovf_sel_e;

  typedef enum logic [1:0] {
    ZS_KEEP  = 2'd0,
    ZS_ALL   = 2'd1,
    ZS_MID   = 2'd2,
    ZS_KEEP2 = 2'd3
  } zero_sel_e;

  typedef enum logic [1:0] {
    NS_KEEP  = 2'd0,
    NS_WIDE  = 2'd1,
    NS_WORD  = 2'd2,
    NS_KEEP2 = 2'd3
  } neg_sel_e;

  typedef struct packed {
    logic c;
    logic v;
    logic sv;
    logic z;
    logic n;
    logic e;
    logic u;
  } flag_set_t;

  function automatic logic add_carry(input logic d, input logic s, input logic r);
    return (d & s) | (~r & (d | s));
  endfunction

  function automatic logic sub_carry(input logic d, input logic s, input logic r);
    return (d & ~s) | (~r & (d | ~s));
  endfunction

endpackage

// File: rtl/acc_flag_rstsync.sv
module acc_flag_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/acc_flag_carry.sv
module acc_flag_carry
  import acc_flag_pkg::*;
(
  input  logic       cur,
  input  logic [2:0] sel,
  input  logic       d_top,
  input  logic       s_top,
  input  logic       s_half,
  input  logic       r_top,
  output logic       nxt
);
  always_comb begin
    unique case (carry_sel_e'(sel))
      CS_CLR:   nxt = 1'b0;
      CS_ADD:   nxt = add_carry(d_top, s_top, r_top);
      CS_SUB:   nxt = sub_carry(d_top, s_top, r_top);
      CS_MIXED: nxt = (d_top ^ s_half) ? add_carry(d_top, s_half, r_top)
                                       : sub_carry(d_top, s_half, r_top);
      CS_NDNR:  nxt = ~d_top & ~r_top;
      CS_DNR:   nxt = d_top & ~r_top;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/acc_flag_ovf.sv
module acc_flag_ovf
  import acc_flag_pkg::*;
(
  input  logic       cur,
  input  logic [2:0] sel,
  input  logic       d_top,
  input  logic       s_top,
  input  logic       r_top,
  output logic       nxt
);
  always_comb begin
    unique case (ovf_sel_e'(sel))
      VS_CLR:  nxt = 1'b0;
      VS_ADD:  nxt = (d_top & s_top & ~r_top) | (~d_top & ~s_top & r_top);
      VS_SUB:  nxt = (d_top & ~s_top & ~r_top) | (~d_top & s_top & r_top);
      VS_DR:   nxt = d_top & r_top;
      VS_NDR:  nxt = ~d_top & r_top;
      VS_R:    nxt = r_top;
      VS_DNR:  nxt = d_top & ~r_top;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/acc_flag_shape.sv
module acc_flag_shape
  import acc_flag_pkg::*;
#(
  parameter int WIDE_W = 40,
  parameter int WORD_W = 32,
  parameter int HALF_W = 16
) (
  input  logic [WIDE_W-1:0] res,
  input  logic [1:0]        z_sel,
  input  logic [1:0]        n_sel,
  input  logic              e_upd,
  input  logic              u_upd,
  input  logic              z_cur,
  input  logic              n_cur,
  input  logic              e_cur,
  input  logic              u_cur,
  output logic              z_nxt,
  output logic              n_nxt,
  output logic              e_nxt,
  output logic              u_nxt
);
  localparam int EXT_W = WIDE_W - WORD_W + 1;

  logic [EXT_W-1:0] ext_field;
  logic             ext_bad;

  assign ext_field = res[WIDE_W-1:WORD_W-1];
  assign ext_bad   = ~((&ext_field) | ~(|ext_field));

  always_comb begin
    unique case (zero_sel_e'(z_sel))
      ZS_ALL:  z_nxt = ~(|res);
      ZS_MID:  z_nxt = ~(|res[WORD_W-1:HALF_W]);
      default: z_nxt = z_cur;
    endcase

    unique case (neg_sel_e'(n_sel))
      NS_WIDE: n_nxt = res[WIDE_W-1];
      NS_WORD: n_nxt = res[WORD_W-1];
      default: n_nxt = n_cur;
    endcase

    e_nxt = e_upd ? ext_bad : e_cur;
    u_nxt = u_upd ? ~(res[WORD_W-1] ^ res[WORD_W-2]) : u_cur;
  end
endmodule

// File: rtl/acc_flag_gen.sv
module acc_flag_gen
  import acc_flag_pkg::*;
#(
  parameter int WIDE_W = 40,
  parameter int WORD_W = 32,
  parameter int HALF_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              sv_clr,
  input  logic [WIDE_W-1:0] dst,
  input  logic [WIDE_W-1:0] src,
  input  logic [WIDE_W-1:0] res,
  input  logic [2:0]        c_sel,
  input  logic [2:0]        v_sel,
  input  logic [1:0]        z_sel,
  input  logic [1:0]        n_sel,
  input  logic              e_upd,
  input  logic              u_upd,
  output logic              flag_c,
  output logic              flag_v,
  output logic              flag_sv,
  output logic              flag_z,
  output logic              flag_n,
  output logic              flag_e,
  output logic              flag_u
);
  localparam int TOP = WIDE_W - 1;
  localparam int HMS = HALF_W - 1;
  localparam int EXT_W = WIDE_W - WORD_W + 1;

  logic      rst_q_n;
  flag_set_t st_q, st_nxt, rule_nxt;
  logic      st_upd;

  acc_flag_rstsync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  acc_flag_carry u_carry (
    .cur(st_q.c), .sel(c_sel), .d_top(dst[TOP]), .s_top(src[TOP]),
    .s_half(src[HMS]), .r_top(res[TOP]), .nxt(rule_nxt.c)
  );

  acc_flag_ovf u_ovf (
    .cur(st_q.v), .sel(v_sel), .d_top(dst[TOP]), .s_top(src[TOP]),
    .r_top(res[TOP]), .nxt(rule_nxt.v)
  );

  acc_flag_shape #(.WIDE_W(WIDE_W), .WORD_W(WORD_W), .HALF_W(HALF_W)) u_shape (
    .res(res), .z_sel(z_sel), .n_sel(n_sel), .e_upd(e_upd), .u_upd(u_upd),
    .z_cur(st_q.z), .n_cur(st_q.n), .e_cur(st_q.e), .u_cur(st_q.u),
    .z_nxt(rule_nxt.z), .n_nxt(rule_nxt.n), .e_nxt(rule_nxt.e), .u_nxt(rule_nxt.u)
  );

  assign rule_nxt.sv = st_q.sv | rule_nxt.v;

  // next-state: enable gates rule results, clear overrides sticky set
  always_comb begin
    st_nxt = upd_en ? rule_nxt : st_q;
    if (sv_clr) st_nxt.sv = 1'b0;
  end

  assign st_upd = upd_en | sv_clr;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    st_q <= '0;
    else if (st_upd) st_q <= st_nxt;
  end

  assign flag_c  = st_q.c;
  assign flag_v  = st_q.v;
  assign flag_sv = st_q.sv;
  assign flag_z  = st_q.z;
  assign flag_n  = st_q.n;
  assign flag_e  = st_q.e;
  assign flag_u  = st_q.u;

  // R11: without enable only sticky may move
  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_q_n)
    !upd_en |=> $stable({flag_c, flag_v, flag_z, flag_n, flag_e, flag_u}));

  // R6: sticky never falls without a clear
  a_r6_sticky_no_drop: assert property (@(posedge clk) disable iff (!rst_q_n)
    flag_sv && !sv_clr |=> flag_sv);

  // R6: an overflow seen on an enabled edge is collected
  a_r6_sticky_collects: assert property (@(posedge clk) disable iff (!rst_q_n)
    upd_en && !sv_clr |=> (!flag_v || flag_sv));

  // R9: extension follows the 9-bit window of the last result
  a_r9_ext_window: assert property (@(posedge clk) disable iff (!rst_q_n)
    upd_en && e_upd |=> flag_e == (($past(res[TOP:WORD_W-1]) != {EXT_W{1'b0}}) &&
                                   ($past(res[TOP:WORD_W-1]) != {EXT_W{1'b1}})));

  // R10: unnormalized is set when bits 31 and 30 agree
  a_r10_unnorm: assert property (@(posedge clk) disable iff (!rst_q_n)
    upd_en && e_upd && u_upd |=> flag_u == ($past(res[WORD_W-1]) == $past(res[WORD_W-2])));

  // R6: clear wins over set
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_q_n)
    sv_clr |=> !flag_sv);
endmodule

// File: tb/acc_flag_gen_bench.sv
module acc_flag_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_en, sv_clr, e_upd, u_upd;
  logic [39:0] dst, src, res;
  logic [2:0]  c_sel, v_sel;
  logic [1:0]  z_sel, n_sel;
  logic        flag_c, flag_v, flag_sv, flag_z, flag_n, flag_e, flag_u;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  bit m_c, m_v, m_sv, m_z, m_n, m_e, m_u;

  always #10 clk = ~clk;

  acc_flag_gen u_acc_flag_gen (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .sv_clr(sv_clr),
    .dst(dst), .src(src), .res(res), .c_sel(c_sel), .v_sel(v_sel),
    .z_sel(z_sel), .n_sel(n_sel), .e_upd(e_upd), .u_upd(u_upd),
    .flag_c(flag_c), .flag_v(flag_v), .flag_sv(flag_sv), .flag_z(flag_z),
    .flag_n(flag_n), .flag_e(flag_e), .flag_u(flag_u)
  );

  // reference model, written from the requirement text
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_c, m_v, m_sv, m_z, m_n, m_e, m_u} = '0;
    end else begin
      if (upd_en) begin
        bit d, s, r, h;
        int top9;
        d = dst[39]; s = src[39]; r = res[39]; h = src[15];
        case (c_sel)
          1: m_c = 0;
          2: m_c = (d && s) || (!r && (d || s));
          3: m_c = (d && !s) || (!r && (d || !s));
          4: if (d != h) m_c = (d && h) || (!r && (d || h));
             else        m_c = (d && !h) || (!r && (d || !h));
          5: m_c = !d && !r;
          6: m_c = d && !r;
          default: ;
        endcase
        case (v_sel)
          1: m_v = 0;
          2: m_v = (d == s) && (r != d);
          3: m_v = (d != s) && (r != d);
          4: m_v = d && r;
          5: m_v = !d && r;
          6: m_v = r;
          7: m_v = d && !r;
          default: ;
        endcase
        if (z_sel == 1) m_z = (res == 40'd0);
        if (z_sel == 2) m_z = (res[31:16] == 16'd0);
        if (n_sel == 1) m_n = res[39];
        if (n_sel == 2) m_n = res[31];
        top9 = int'(res[39:31]);
        if (e_upd) m_e = !(top9 == 0 || top9 == 511);
        if (u_upd) m_u = (res[31] == res[30]);
      end
      if (sv_clr) m_sv = 0;
      else if (upd_en && m_v) m_sv = 1;
    end
  end

  function automatic string c_tag();
    if (!upd_en || c_sel == 0 || c_sel == 7) return "R11";
    if (c_sel == 4) return "R3";
    if (c_sel >= 5) return "R4";
    return "R2";
  endfunction

  task automatic cmp1(input string tag, input string nm, input bit act, input bit exp_v);
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s flag %s: actual %0b expected %0b at cycle %0d", tag, nm, act, exp_v, cyc);
    end
  endtask

  // sample at negedge: the stimulus still applied is the one of the last edge (R12)
  task automatic check_all();
    n_vec++;
    cmp1(c_tag(), "C", flag_c, m_c);
    cmp1((upd_en && v_sel != 0) ? "R5" : "R11", "V", flag_v, m_v);
    cmp1("R6", "SV", flag_sv, m_sv);
    cmp1((upd_en && (z_sel == 1 || z_sel == 2)) ? "R7" : "R11", "Z", flag_z, m_z);
    cmp1((upd_en && (n_sel == 1 || n_sel == 2)) ? "R8" : "R11", "N", flag_n, m_n);
    cmp1((upd_en && e_upd) ? "R9" : "R11", "E", flag_e, m_e);
    cmp1((upd_en && u_upd) ? "R10" : "R11", "U", flag_u, m_u);
  endtask

  task automatic step(input bit en, input bit clr, input logic [39:0] d, input logic [39:0] s,
                      input logic [39:0] r, input int cs, input int vs, input int zs,
                      input int ns, input bit eu, input bit uu);
    @(negedge clk);
    check_all();
    upd_en = en; sv_clr = clr; dst = d; src = src; src = s; res = r;
    c_sel = 3'(cs); v_sel = 3'(vs); z_sel = 2'(zs); n_sel = 2'(ns);
    e_upd = eu; u_upd = uu;
  endtask

  function automatic logic [39:0] rnd40();
    logic [63:0] w;
    w = {$urandom, $urandom};
    case ($urandom_range(0, 4))
      0: w[39:31] = '0;
      1: w[39:31] = '1;
      2: w[31:16] = '0;
      default: ;
    endcase
    return w[39:0];
  endfunction

  always @(posedge clk) cyc++;

  initial begin
    wait (cyc > 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    upd_en = 0; sv_clr = 0; dst = '0; src = '0; res = '0;
    c_sel = 0; v_sel = 0; z_sel = 0; n_sel = 0; e_upd = 0; u_upd = 0;
    repeat (3) @(negedge clk);
    check_all(); // R1 during reset
    rst_n = 1'b1;
    // R1: two edges after release still held in reset; drive enables with set values
    step(1, 0, 40'hFF_FFFF_FFFF, 40'h80_0000_0000, 40'h7F_8000_0000, 6, 6, 2, 1, 1, 1);
    @(negedge clk);
    if ({flag_c, flag_v, flag_sv, flag_z, flag_n, flag_e, flag_u} !== 7'd0) begin
      n_bad++;
      $display("FAIL R1 flags during reset release: actual %b expected 0000000",
               {flag_c, flag_v, flag_sv, flag_z, flag_n, flag_e, flag_u});
    end
    n_vec++;
    upd_en = 0;
    repeat (4) @(negedge clk);
    // model was updated on those edges while the design was still in reset; realign
    {m_c, m_v, m_sv, m_z, m_n, m_e, m_u} = '0;

    // R2: true add carry out, and subtract
    step(1, 0, 40'h80_0000_0001, 40'h80_0000_0000, 40'h00_0000_0001, 2, 2, 1, 1, 1, 1);
    step(1, 0, 40'h00_0000_0005, 40'h00_0000_0007, 40'hFF_FFFF_FFFE, 3, 3, 2, 2, 1, 1);
    // R3: mixed rule both branches
    step(1, 0, 40'h80_0000_0000, 40'h00_0000_8000, 40'h00_0000_0000, 4, 6, 0, 0, 0, 0);
    step(1, 0, 40'h80_0000_0000, 40'h00_0000_0000, 40'h00_0000_0000, 4, 7, 0, 0, 0, 0);
    step(1, 0, 40'h00_0000_0000, 40'h00_0000_8000, 40'h80_0000_0000, 4, 5, 0, 0, 0, 0);
    // R4
    step(1, 0, 40'h00_0000_0000, 40'h0, 40'h00_0000_0000, 5, 4, 0, 0, 0, 0);
    step(1, 0, 40'h80_0000_0000, 40'h0, 40'h00_0000_0000, 6, 1, 0, 0, 0, 0);
    // R9 window edges: all zeros, all ones, single bits at each end
    step(1, 0, 40'h0, 40'h0, 40'h00_7FFF_FFFF, 0, 0, 1, 0, 1, 1);
    step(1, 0, 40'h0, 40'h0, 40'hFF_8000_0000, 0, 0, 1, 0, 1, 1);
    step(1, 0, 40'h0, 40'h0, 40'h00_8000_0000, 0, 0, 2, 0, 1, 1);
    step(1, 0, 40'h0, 40'h0, 40'h80_0000_0000, 0, 0, 1, 0, 1, 1);
    step(1, 0, 40'h0, 40'h0, 40'hFF_7FFF_FFFF, 0, 0, 0, 1, 1, 1);
    // R7: mid zero true while other bits set
    step(1, 0, 40'hFF, 40'h0, 40'hFF_0000_FFFF, 0, 0, 2, 2, 0, 1);
    // R6: set sticky, then clear while overflow is set again (clear wins)
    step(1, 0, 40'h0, 40'h0, 40'h80_0000_0000, 0, 6, 0, 0, 0, 0);
    step(1, 1, 40'h0, 40'h0, 40'h80_0000_0000, 0, 6, 0, 0, 0, 0);
    step(0, 0, 40'h0, 40'h0, 40'h0, 0, 0, 0, 0, 0, 0);
    // R11: disabled with active selects, then keep codes while enabled
    step(0, 0, 40'h80_0000_0000, 40'h0, 40'h0, 6, 1, 1, 2, 1, 1);
    step(1, 0, 40'h80_0000_0000, 40'h0, 40'h0, 7, 0, 3, 3, 0, 0);
    step(1, 0, 40'h80_0000_0000, 40'h0, 40'h0, 0, 0, 0, 0, 0, 0);

    for (int i = 0; i < 6000; i++) begin
      logic [39:0] d, s, r;
      int k;
      d = rnd40(); s = rnd40();
      k = $urandom_range(0, 2);
      r = (k == 0) ? d + s : (k == 1) ? d - s : rnd40();
      step($urandom_range(0, 7) != 0, $urandom_range(0, 15) == 0, d, s, r,
           $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 3),
           $urandom_range(0, 3), $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end
    step(0, 0, 40'h0, 40'h0, 40'h0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_all();

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule